// File: doc/BRIEF.md
# Keyed Block Pairing Table Builder

This block turns a secret key into a one-to-one pairing of image-block indices. A start pulse supplies a 32-bit key and an even block count. The block writes the identity sequence into an index store, scrambles it with a keyed pseudo-random shuffle, and then builds a partner table. In that table the entry of every block holds the index of the block it is paired with. A sender that embeds check data and a receiver that verifies it each run their own copy with the same key, and both get the same partner table.

The shuffle swaps entries from the top index downward. Each swap position comes from a 32-bit Galois LFSR, reduced modulo the current range by a serial remainder unit. After the shuffle, the scrambled sequence is split into a lower half and an upper half. Entries at equal offsets in the two halves become partners, and both directions are recorded. Once the done flag is up, a lookup port returns the partner of any index one cycle after the index is presented.

Top module: `shuf_pair_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are all low.
- R2: A start whose count is zero, odd or above `N_MAX` raises `err_o` in the cycle after the start. `busy_o` and `done_o` stay low and no table is built. The next start clears `err_o`.
- R3: A start with a valid count raises `busy_o` and lowers `done_o` and `err_o` in the cycle after the start. `busy_o` stays high until the cycle in which `done_o` rises, and the two are never high together.
- R4: The index store first holds i at position i for i = 0..count-1. For i from count-1 down to 1, the LFSR advances once, j = state mod (i+1), and positions i and j are swapped.
- R5: The LFSR loads the key, or 32'h0000_0001 when the key is zero. One advance is next = (s >> 1) XOR (s[0] ? 32'hA300_0000 : 0).
- R6: With h = count/2, for every k < h the blocks at shuffled positions k and k+h are partners. The table holds each one at the other's index.
- R7: Every index below count has exactly one partner, the partner is different from the index, and the partner's partner is the index again.
- R8: While `done_o` is high, `lk_partner_o` shows the table entry of the `lk_idx_i` value from the previous cycle.
- R9: The same key and count always give the same table, and two different keys give different tables.
- R10: A start during a build abandons that build and starts a new one. The resulting table depends only on the new key and count.
- R11: `done_o` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new build (one-cycle pulse) |
| key_i | input | 32 | Shuffle key |
| count_i | input | CNT_W | Number of blocks |
| busy_o | output | 1 | Build in progress |
| done_o | output | 1 | Partner table ready |
| err_o | output | 1 | Last start was rejected |
| lk_idx_i | input | IDX_W | Block index to look up |
| lk_partner_o | output | IDX_W | Partner of the index presented in the previous cycle |

## Verification
The build is run at the largest count, at the smallest count of two, and at a small count that is not a power of two. These three separate range and boundary faults in the remainder and the half split. A zero key exercises the LFSR seed fallback. Repeating a key and then changing it shows whether the table really depends on the key. A restart in the middle of a build shows whether any state leaks from the abandoned run into the new one. Zero, odd and oversize counts exercise the rejection path. Every table read back is compared entry by entry against a behavioural model and is also checked for symmetry and for self-pairing.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam logic [31:0] LFSR_MASK = 32'hA300_0000;
  localparam logic [31:0] LFSR_ZERO_SEED = 32'h0000_0001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_STEP,
    ST_DIVGO,
    ST_DIV,
    ST_SWAPA,
    ST_SWAPB,
    ST_PAIRA,
    ST_PAIRB,
    ST_DONE
  } shuf_state_e;
endpackage

// File: rtl/shuf_lfsr.sv
module shuf_lfsr
  import shuf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] seed_i,
  input  logic        step_i,
  output logic [31:0] state_o
);
  logic [31:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LFSR_ZERO_SEED;
    end else if (load_i) begin
      state_q <= (seed_i == '0) ? LFSR_ZERO_SEED : seed_i;
    end else if (step_i) begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? LFSR_MASK : 32'h0);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/shuf_modrem.sv
// Serial restoring remainder: one dividend bit per cycle.
module shuf_modrem #(
  parameter int DW = 32,
  parameter int VW = 7,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [VW-1:0] rem_o
);
  logic [DW-1:0] dvd_q;
  logic [VW-1:0] rem_q, rem_nxt;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [VW:0]   trial;

  always_comb begin
    trial = {rem_q, dvd_q[DW-1]};
    if (trial >= {1'b0, divisor_i}) rem_nxt = VW'(trial - {1'b0, divisor_i});
    else                            rem_nxt = trial[VW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dvd_q  <= dividend_i;
        rem_q  <= '0;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q <= {dvd_q[DW-2:0], 1'b0};
        rem_q <= rem_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/shuf_mem.sv
module shuf_mem #(
  parameter int DEPTH    = 64,
  parameter int AW       = 6,
  parameter int DW       = 6,
  parameter int RD_PORTS = 2
) (
  input  logic                              clk_i,
  input  logic                              we_i,
  input  logic [AW-1:0]                     waddr_i,
  input  logic [DW-1:0]                     wdata_i,
  input  logic [RD_PORTS-1:0][AW-1:0]       raddr_i,
  output logic [RD_PORTS-1:0][DW-1:0]       rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/shuf_pair_gen.sv
module shuf_pair_gen
  import shuf_pkg::*;
#(
  parameter int N_MAX = 64,
  parameter int IDX_W = $clog2(N_MAX),
  parameter int CNT_W = $clog2(N_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      key_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [IDX_W-1:0] lk_partner_o
);
  shuf_state_e      state_q;
  logic [CNT_W-1:0] cnt_q, half_q, ptr_q;
  logic [IDX_W-1:0] j_q, va_q, vb_q, lk_q;
  logic             err_q;
  logic             cnt_bad;

  logic [31:0]      lfsr_state;
  logic             lfsr_load, lfsr_step;
  logic             mod_start, mod_done;
  logic [CNT_W-1:0] mod_rem;

  logic                         perm_we;
  logic [IDX_W-1:0]             perm_waddr, perm_wdata;
  logic [1:0][IDX_W-1:0]        perm_raddr, perm_rdata;
  logic                         part_we;
  logic [IDX_W-1:0]             part_waddr, part_wdata;
  logic [0:0][IDX_W-1:0]        part_raddr, part_rdata;

  assign cnt_bad = (count_i == '0) || count_i[0] || (count_i > CNT_W'(N_MAX));

  assign lfsr_load = start_i && !cnt_bad;
  assign lfsr_step = !start_i && (state_q == ST_STEP);
  assign mod_start = !start_i && (state_q == ST_DIVGO);

  shuf_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lfsr_load),
    .seed_i  (key_i),
    .step_i  (lfsr_step),
    .state_o (lfsr_state)
  );

  shuf_modrem #(.DW(32), .VW(CNT_W)) u_mod (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (mod_start),
    .dividend_i (lfsr_state),
    .divisor_i  (ptr_q + 1'b1),
    .done_o     (mod_done),
    .rem_o      (mod_rem)
  );

  always_comb begin
    perm_we       = 1'b0;
    perm_waddr    = ptr_q[IDX_W-1:0];
    perm_wdata    = ptr_q[IDX_W-1:0];
    perm_raddr[0] = ptr_q[IDX_W-1:0];
    perm_raddr[1] = (state_q == ST_PAIRA) ? IDX_W'(ptr_q + half_q) : j_q;
    part_we       = 1'b0;
    part_waddr    = perm_rdata[0];
    part_wdata    = perm_rdata[1];
    part_raddr[0] = lk_idx_i;
    if (!start_i) begin
      unique case (state_q)
        ST_FILL:  perm_we = 1'b1;
        ST_SWAPA: begin
          perm_we    = 1'b1;
          perm_wdata = perm_rdata[1];
        end
        ST_SWAPB: begin
          perm_we    = 1'b1;
          perm_waddr = j_q;
          perm_wdata = va_q;
        end
        ST_PAIRA: part_we = 1'b1;
        ST_PAIRB: begin
          part_we    = 1'b1;
          part_waddr = vb_q;
          part_wdata = va_q;
        end
        default: ;
      endcase
    end
  end

  shuf_mem #(.DEPTH(N_MAX), .AW(IDX_W), .DW(IDX_W), .RD_PORTS(2)) u_perm (
    .clk_i   (clk_i),
    .we_i    (perm_we),
    .waddr_i (perm_waddr),
    .wdata_i (perm_wdata),
    .raddr_i (perm_raddr),
    .rdata_o (perm_rdata)
  );

  shuf_mem #(.DEPTH(N_MAX), .AW(IDX_W), .DW(IDX_W), .RD_PORTS(1)) u_part (
    .clk_i   (clk_i),
    .we_i    (part_we),
    .waddr_i (part_waddr),
    .wdata_i (part_wdata),
    .raddr_i (part_raddr),
    .rdata_o (part_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      ptr_q   <= '0;
      j_q     <= '0;
      va_q    <= '0;
      vb_q    <= '0;
      err_q   <= 1'b0;
      lk_q    <= '0;
    end else begin
      lk_q <= part_rdata[0];
      if (start_i) begin
        if (cnt_bad) begin
          err_q   <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          err_q   <= 1'b0;
          cnt_q   <= count_i;
          half_q  <= count_i >> 1;
          ptr_q   <= '0;
          state_q <= ST_FILL;
        end
      end else begin
        unique case (state_q)
          ST_FILL: begin
            if (ptr_q == cnt_q - 1'b1) state_q <= ST_STEP;
            else                       ptr_q   <= ptr_q + 1'b1;
          end
          ST_STEP:  state_q <= ST_DIVGO;
          ST_DIVGO: state_q <= ST_DIV;
          ST_DIV: begin
            if (mod_done) begin
              j_q     <= IDX_W'(mod_rem);
              state_q <= ST_SWAPA;
            end
          end
          ST_SWAPA: begin
            va_q    <= perm_rdata[0];
            state_q <= ST_SWAPB;
          end
          ST_SWAPB: begin
            if (ptr_q == CNT_W'(1)) begin
              ptr_q   <= '0;
              state_q <= ST_PAIRA;
            end else begin
              ptr_q   <= ptr_q - 1'b1;
              state_q <= ST_STEP;
            end
          end
          ST_PAIRA: begin
            va_q    <= perm_rdata[0];
            vb_q    <= perm_rdata[1];
            state_q <= ST_PAIRB;
          end
          ST_PAIRB: begin
            if (ptr_q == half_q - 1'b1) state_q <= ST_DONE;
            else                        begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_PAIRA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = err_q;
  assign lk_partner_o = lk_q;
endmodule

// File: rtl/shuf_pair_gen_chk.sv
module shuf_pair_gen_chk #(
  parameter int N_MAX = 64,
  parameter int IDX_W = $clog2(N_MAX),
  parameter int CNT_W = $clog2(N_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [IDX_W-1:0] lk_idx_i,
  input logic [IDX_W-1:0] lk_partner_o
);
  logic bad;
  assign bad = (count_i == '0) || count_i[0] || (count_i > CNT_W'(N_MAX));

  assert_busy_done_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));

  assert_bad_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bad) |=> (err_o && !busy_o && !done_o));

  assert_good_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !bad) |=> (busy_o && !err_o && !done_o));

  assert_busy_until_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (busy_o || done_o));

  assert_done_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_lookup_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o) && $stable(lk_idx_i)) |=> $stable(lk_partner_o));
endmodule

bind shuf_pair_gen shuf_pair_gen_chk #(.N_MAX(N_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .count_i      (count_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .lk_idx_i     (lk_idx_i),
  .lk_partner_o (lk_partner_o)
);

// File: tb/sim_shuf_pair_gen.sv
module sim_shuf_pair_gen;
  localparam int N  = 64;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   key = '0;
  logic [CW-1:0] count = '0;
  logic          busy, done, err;
  logic [IW-1:0] lk_idx = '0;
  logic [IW-1:0] lk_partner;

  int checks = 0;
  int fails  = 0;
  bit exp_err = 1'b0;
  bit mon_on  = 1'b0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  int ref_tab [N];
  int dut_tab [N];
  int save_tab [N];

  always #5 clk = ~clk;

  shuf_pair_gen #(.N_MAX(N)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .key_i (key), .count_i (count),
    .busy_o (busy), .done_o (done), .err_o (err),
    .lk_idx_i (lk_idx), .lk_partner_o (lk_partner)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned lfsr_next(input int unsigned s);
    return (s >> 1) ^ ((s & 1) != 0 ? 32'hA300_0000 : 32'h0);
  endfunction

  // R4 R5 R6: behavioural reference
  task automatic build_ref(input int unsigned k, input int cnt);
    int perm[$];
    int unsigned s;
    int h;
    perm = {};
    for (int i = 0; i < cnt; i++) perm.push_back(i);
    s = (k == 0) ? 32'd1 : k;
    for (int i = cnt - 1; i >= 1; i--) begin
      int j, t;
      s = lfsr_next(s);
      j = int'(s % (i + 1));
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    h = cnt / 2;
    for (int i = 0; i < N; i++) ref_tab[i] = -1;
    for (int i = 0; i < h; i++) begin
      ref_tab[perm[i]]     = perm[i + h];
      ref_tab[perm[i + h]] = perm[i];
    end
  endtask

  // per-clock monitor, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      check(err == exp_err, "R2", err, exp_err);
      check(!(busy && done), "R3", busy, 0);
      check(!(prev_done && !done && !start), "R11", done, 1);
      prev_done = done;
    end
  end

  task automatic do_start(input int unsigned k, input int cnt, input bit bad);
    @(negedge clk);
    start = 1'b1; key = k; count = CW'(cnt); exp_err = bad;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      check(err && !busy && !done, "R2", {err, busy, done}, 4);
    end else begin
      check(busy && !done && !err, "R3", {err, busy, done}, 2);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, done, 1);
  endtask

  task automatic read_table(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      lk_idx = IW'(i);
      @(negedge clk);
      dut_tab[i] = int'(lk_partner);
    end
  endtask

  task automatic verify(input int unsigned k, input int cnt, input string req);
    build_ref(k, cnt);
    read_table(cnt);
    for (int i = 0; i < cnt; i++)
      check(dut_tab[i] == ref_tab[i], req, dut_tab[i], ref_tab[i]);
    for (int i = 0; i < cnt; i++) begin
      check(dut_tab[i] != i && dut_tab[i] < cnt, "R7", dut_tab[i], i);
      check(dut_tab[dut_tab[i]] == i, "R7", dut_tab[dut_tab[i]], i);
    end
  endtask

  task automatic run_case(input int unsigned k, input int cnt, input string req);
    do_start(k, cnt, 1'b0);
    wait_done(req);
    verify(k, cnt, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1", {err, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R1", {err, busy, done}, 0);
    prev_done = 1'b0;
    mon_on = 1'b1;

    // full-range build, R4 R5 R6
    run_case(32'h1234_5678, N, "R6");
    for (int i = 0; i < N; i++) save_tab[i] = dut_tab[i];

    // R11: done holds with no start
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R11", done, 1);

    // R9: same key reproduces
    run_case(32'h1234_5678, N, "R9");
    begin
      int same = 1;
      for (int i = 0; i < N; i++) if (dut_tab[i] != save_tab[i]) same = 0;
      check(same == 1, "R9", same, 1);
    end

    // R9: different key differs
    run_case(32'hCAFE_0001, N, "R4");
    begin
      int diff = 0;
      for (int i = 0; i < N; i++) if (dut_tab[i] != save_tab[i]) diff = 1;
      check(diff == 1, "R9", diff, 1);
    end

    // smallest count and odd-range count
    run_case(32'h0BAD_F00D, 2, "R6");
    run_case(32'h5555_AAAA, 10, "R4");

    // R5: zero key fallback
    run_case(32'h0, 34, "R5");

    // R2: rejected counts
    do_start(32'h1, 7, 1'b1);
    repeat (20) @(negedge clk);
    check(!busy && !done, "R2", {busy, done}, 0);
    do_start(32'h1, 0, 1'b1);
    do_start(32'h1, N + 2, 1'b1);
    repeat (10) @(negedge clk);
    check(!busy && !done, "R2", {busy, done}, 0);

    // R10: restart mid-build
    do_start(32'hAAAA_0000, N, 1'b0);
    repeat (300) @(negedge clk);
    check(busy == 1'b1, "R10", busy, 1);
    run_case(32'h7777_1111, N, "R10");

    // restart right after done
    run_case(32'h0000_0003, 16, "R10");

    finished = 1'b1;
    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule